// File: doc/BRIEF.md
# Dual-Channel Programmable GPIO Register Block

This block gives software a small register window onto one or two banks of general-purpose pins, each bank `WIDTH` bits wide. For every pin, a direction bit selects input or output. Output pins drive the stored data value toward the pad, together with an active-high output enable. Input pins are sampled through a two-flop synchronizer. Reading a data register returns a per-bit blend: the synchronized pin value for inputs and the stored value for outputs.

The register bus is a plain single-beat port. An access is presented by holding `bus_sel` high for one cycle, together with the address, the write flag, the write data and the byte enables. Exactly one cycle later `bus_ack` pulses, and on a read `bus_rdata` is valid in that same cycle. There is no back-pressure, so a new access may be presented in any cycle. Build parameters choose the following: whether the second channel exists, whether each channel takes its inputs from the bidirectional pad input or from a dedicated input-only vector, whether each channel is built inputs-only, and the reset contents of every register.

Top module: `gpio_regblk`

## Requirements
- R1: Word-aligned byte offsets select the registers: 0x0 is the channel-1 data register, 0x4 the channel-1 direction register, 0x8 the channel-2 data register and 0xC the channel-2 direction register. Address bits [1:0] must be zero and all bits above bit 3 must be zero.
- R2: `bus_ack` is high in exactly the cycle after each cycle in which `bus_sel` is high, and low otherwise. Read data is presented on `bus_rdata` in that acknowledge cycle. After a write, `bus_rdata` is zero.
- R3: At reset, each data register loads its `DATA_RSTn` parameter and each direction register loads its `DIR_RSTn` parameter. The defaults are data all zeros and direction all ones, so every pin starts as an input with its output enable low.
- R4: A direction bit of 1 makes the pin an input and drives its `chN_oe_o` bit to 0. A direction bit of 0 makes the pin an output, with `chN_oe_o` high and `chN_dout_o` carrying the stored data bit.
- R5: A read of a data register returns, bit by bit, the synchronized pin value where the direction bit is 1 and the stored data value where it is 0.
- R6: A data-register write changes only the bits whose direction bit is 0. Bits configured as inputs keep their stored value, which becomes visible on `chN_dout_o` once the pin is switched to output.
- R7: Byte enable `bus_be[i]` qualifies write-data bits [8i+7:8i] for both data and direction writes. Bits in disabled lanes keep their value.
- R8: When `BIDIRn` is 1, channel n samples `chN_pad_i`. When it is 0, channel n samples `chN_in_i`.
- R9: A pin value that is stable before clock edge k is returned by a read whose `bus_sel` is captured at edge k+2 or later. A read captured at edge k+1 still returns the previous value.
- R10: With `INPUTS_ONLYn` set, the channel's direction register reads as zero and ignores writes, its data register ignores writes, its data reads always return the pins, and both `chN_dout_o` and `chN_oe_o` are held at zero.
- R11: With `DUAL` at 0, offsets 0x8 and 0xC read as zero and ignore writes, and the channel-2 output vectors are held at zero.
- R12: A read of an unmapped or misaligned address returns zero, and a write to one changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write enables |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access acknowledge, one cycle after bus_sel |
| ch1_pad_i | input | WIDTH | Channel 1 bidirectional pad input |
| ch1_in_i | input | WIDTH | Channel 1 dedicated input vector |
| ch1_dout_o | output | WIDTH | Channel 1 output data |
| ch1_oe_o | output | WIDTH | Channel 1 output enable, active high |
| ch2_pad_i | input | WIDTH | Channel 2 bidirectional pad input |
| ch2_in_i | input | WIDTH | Channel 2 dedicated input vector |
| ch2_dout_o | output | WIDTH | Channel 2 output data |
| ch2_oe_o | output | WIDTH | Channel 2 output enable, active high |

## Verification
An access captured at one rising edge produces its acknowledge, its read data and any register or pin-output change exactly one cycle later. The bench drives each access just after a falling edge and samples all outputs half a cycle after the capturing edge. A pin change needs two more edges to reach a read. The random stimulus therefore holds pins stable for three cycles after any change before it reads. A directed test reads right after a change, expecting the old value, and then reads again, expecting the new one. Both bench instances are checked on every access: a dual, bidirectional-plus-dedicated build and a single-channel, inputs-only, narrower build.

// File: rtl/gpio_regblk_pkg.sv
package gpio_regblk_pkg;

  localparam int BUS_DW = 32;
  localparam int BUS_BW = BUS_DW / 8;

  typedef enum logic [1:0] {
    SEL_C1_DATA = 2'd0,
    SEL_C1_DIR  = 2'd1,
    SEL_C2_DATA = 2'd2,
    SEL_C2_DIR  = 2'd3
  } reg_sel_e;

  function automatic logic [BUS_DW-1:0] lane_mask(input logic [BUS_BW-1:0] be);
    logic [BUS_DW-1:0] m;
    for (int i = 0; i < BUS_BW; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_chan.sv
module gpio_chan #(
  parameter int          W           = 32,
  parameter bit          INPUTS_ONLY = 1'b0,
  parameter bit          BIDIR       = 1'b1,
  parameter logic [31:0] DATA_RST    = '0,
  parameter logic [31:0] DIR_RST     = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_i,
  input  logic [W-1:0] in_i,
  input  logic         wr_data_en,
  input  logic         wr_dir_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] rd_dir,
  output logic [W-1:0] dout_o,
  output logic [W-1:0] oe_o
);
  logic [W-1:0] pin_raw;
  logic [W-1:0] pin_s;

  // R8: source chosen at build time
  assign pin_raw = BIDIR ? pad_i : in_i;

  gpio_sync2 #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_raw),
    .q    (pin_s)
  );

  generate
    if (INPUTS_ONLY) begin : g_in_only
      // R10: no storage, outputs parked low
      assign rd_data = pin_s;
      assign rd_dir  = '0;
      assign dout_o  = '0;
      assign oe_o    = '0;
    end else begin : g_full
      logic [W-1:0] data_q;
      logic [W-1:0] dir_q;
      logic [W-1:0] data_wmask;

      // R6/R7: only enabled lanes of output-configured bits accept data
      assign data_wmask = wmask & ~dir_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q <= DATA_RST[W-1:0];
          dir_q  <= DIR_RST[W-1:0];
        end else begin
          if (wr_data_en) data_q <= (data_q & ~data_wmask) | (wdata & data_wmask);
          if (wr_dir_en)  dir_q  <= (dir_q & ~wmask) | (wdata & wmask);
        end
      end

      assign rd_data = (pin_s & dir_q) | (data_q & ~dir_q);
      assign rd_dir  = dir_q;
      assign dout_o  = data_q;
      assign oe_o    = ~dir_q;

      // R6: bits that were inputs never change their stored value
      a_r6_input_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((data_q ^ $past(data_q)) & $past(dir_q)) == '0));

      // R4: direction changes only on a direction write
      a_r4_dir_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir_en |=> $stable(dir_q));

      // R6: data register changes only on a data write
      a_r6_data_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data_en |=> $stable(data_q));
    end
  endgenerate
endmodule

// File: rtl/gpio_regblk.sv
module gpio_regblk
  import gpio_regblk_pkg::*;
#(
  parameter int          WIDTH        = 32,
  parameter int          ADDR_W       = 8,
  parameter bit          DUAL         = 1'b1,
  parameter bit          INPUTS_ONLY1 = 1'b0,
  parameter bit          INPUTS_ONLY2 = 1'b0,
  parameter bit          BIDIR1       = 1'b1,
  parameter bit          BIDIR2       = 1'b1,
  parameter logic [31:0] DATA_RST1    = '0,
  parameter logic [31:0] DIR_RST1     = '1,
  parameter logic [31:0] DATA_RST2    = '0,
  parameter logic [31:0] DIR_RST2     = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  input  logic [WIDTH-1:0]  ch1_pad_i,
  input  logic [WIDTH-1:0]  ch1_in_i,
  output logic [WIDTH-1:0]  ch1_dout_o,
  output logic [WIDTH-1:0]  ch1_oe_o,
  input  logic [WIDTH-1:0]  ch2_pad_i,
  input  logic [WIDTH-1:0]  ch2_in_i,
  output logic [WIDTH-1:0]  ch2_dout_o,
  output logic [WIDTH-1:0]  ch2_oe_o
);
  localparam int HI_SHIFT = 4;

  logic [1:0]       ridx;
  reg_sel_e         rsel;
  logic             mapped;
  logic             do_wr;
  logic [BUS_DW-1:0] wmask_full;
  logic [WIDTH-1:0] wmask;
  logic [WIDTH-1:0] wdata;
  logic [WIDTH-1:0] rd_mux;

  logic [WIDTH-1:0] c1_rd_data, c1_rd_dir, c2_rd_data, c2_rd_dir;
  logic [WIDTH-1:0] c2_dout, c2_oe;

  // R1/R11/R12: decode
  assign ridx   = bus_addr[3:2];
  assign rsel   = reg_sel_e'(ridx);
  assign mapped = ((bus_addr >> HI_SHIFT) == '0) && (bus_addr[1:0] == 2'b00)
                  && (!ridx[1] || DUAL);
  assign do_wr  = bus_sel && bus_wr && mapped;

  // R7: byte lanes
  assign wmask_full = lane_mask(bus_be);
  assign wmask      = wmask_full[WIDTH-1:0];
  assign wdata      = bus_wdata[WIDTH-1:0];

  gpio_chan #(
    .W(WIDTH), .INPUTS_ONLY(INPUTS_ONLY1), .BIDIR(BIDIR1),
    .DATA_RST(DATA_RST1), .DIR_RST(DIR_RST1)
  ) u_ch1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_i     (ch1_pad_i),
    .in_i      (ch1_in_i),
    .wr_data_en(do_wr && rsel == SEL_C1_DATA),
    .wr_dir_en (do_wr && rsel == SEL_C1_DIR),
    .wdata     (wdata),
    .wmask     (wmask),
    .rd_data   (c1_rd_data),
    .rd_dir    (c1_rd_dir),
    .dout_o    (ch1_dout_o),
    .oe_o      (ch1_oe_o)
  );

  gpio_chan #(
    .W(WIDTH), .INPUTS_ONLY(INPUTS_ONLY2), .BIDIR(BIDIR2),
    .DATA_RST(DATA_RST2), .DIR_RST(DIR_RST2)
  ) u_ch2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_i     (ch2_pad_i),
    .in_i      (ch2_in_i),
    .wr_data_en(do_wr && rsel == SEL_C2_DATA),
    .wr_dir_en (do_wr && rsel == SEL_C2_DIR),
    .wdata     (wdata),
    .wmask     (wmask),
    .rd_data   (c2_rd_data),
    .rd_dir    (c2_rd_dir),
    .dout_o    (c2_dout),
    .oe_o      (c2_oe)
  );

  // R11: second channel parked when not built
  assign ch2_dout_o = DUAL ? c2_dout : '0;
  assign ch2_oe_o   = DUAL ? c2_oe   : '0;

  always_comb begin
    rd_mux = '0;
    if (mapped) begin
      case (rsel)
        SEL_C1_DATA: rd_mux = c1_rd_data;
        SEL_C1_DIR:  rd_mux = c1_rd_dir;
        SEL_C2_DATA: rd_mux = c2_rd_data;
        SEL_C2_DIR:  rd_mux = c2_rd_dir;
        default:     rd_mux = '0;
      endcase
    end
  end

  // R2: one-cycle registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_sel;
      bus_rdata <= (bus_sel && !bus_wr) ? BUS_DW'(rd_mux) : '0;
    end
  end

  a_r2_ack_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ack);

  a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_ack);

  a_r12_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !mapped) |=> (bus_rdata == '0));

  a_r11_ch2_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !DUAL |-> (ch2_oe_o == '0 && ch2_dout_o == '0));
endmodule

// File: tb/tb_gpio_regblk.sv
module tb_gpio_regblk;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [3:0]  be = '0;

  logic [31:0] a_pad1 = '0, a_in1 = '0, a_pad2 = '0, a_in2 = '0;
  logic [31:0] a_rdata, a_dout1, a_oe1, a_dout2, a_oe2;
  logic        a_ack;

  logic [11:0] b_pad1 = '0, b_in1 = '0, b_pad2 = '0, b_in2 = '0;
  logic [31:0] b_rdata;
  logic [11:0] b_dout1, b_oe1, b_dout2, b_oe2;
  logic        b_ack;

  gpio_regblk #(
    .WIDTH(32), .DUAL(1'b1), .BIDIR1(1'b1), .BIDIR2(1'b0),
    .DATA_RST2(32'hA5A5_0000), .DIR_RST2(32'h0000_FFFF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wd), .bus_be(be), .bus_rdata(a_rdata), .bus_ack(a_ack),
    .ch1_pad_i(a_pad1), .ch1_in_i(a_in1), .ch1_dout_o(a_dout1), .ch1_oe_o(a_oe1),
    .ch2_pad_i(a_pad2), .ch2_in_i(a_in2), .ch2_dout_o(a_dout2), .ch2_oe_o(a_oe2)
  );

  gpio_regblk #(
    .WIDTH(12), .DUAL(1'b0), .INPUTS_ONLY1(1'b1), .BIDIR1(1'b0)
  ) dut_b (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wd), .bus_be(be), .bus_rdata(b_rdata), .bus_ack(b_ack),
    .ch1_pad_i(b_pad1), .ch1_in_i(b_in1), .ch1_dout_o(b_dout1), .ch1_oe_o(b_oe1),
    .ch2_pad_i(b_pad2), .ch2_in_i(b_in2), .ch2_dout_o(b_dout2), .ch2_oe_o(b_oe2)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model of dut
  logic [31:0] m_data1 = 32'h0, m_dir1 = 32'hFFFF_FFFF;
  logic [31:0] m_data2 = 32'hA5A5_0000, m_dir2 = 32'h0000_FFFF;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  function automatic logic [31:0] exp_a(input logic [7:0] ad);
    if (ad[7:4] != 0 || ad[1:0] != 0) return 32'h0;   // R12
    case (ad[3:2])
      2'd0: return (a_pad1 & m_dir1) | (m_data1 & ~m_dir1);  // R5, R8 pad source
      2'd1: return m_dir1;
      2'd2: return (a_in2 & m_dir2) | (m_data2 & ~m_dir2);   // R8 dedicated source
      default: return m_dir2;
    endcase
  endfunction

  function automatic logic [31:0] exp_b(input logic [7:0] ad);
    if (ad == 8'h00) return {20'h0, b_in1};  // R10 reads pins, R8 dedicated source
    return 32'h0;                            // R10 dir, R11 ch2, R12
  endfunction

  task automatic check_pins(input string tag);
    check(a_dout1 == m_data1, {tag, " R4 dout1"}, a_dout1, m_data1);
    check(a_oe1 == ~m_dir1, {tag, " R4 oe1"}, a_oe1, ~m_dir1);
    check(a_dout2 == m_data2, {tag, " R4 dout2"}, a_dout2, m_data2);
    check(a_oe2 == ~m_dir2, {tag, " R4 oe2"}, a_oe2, ~m_dir2);
    check({b_dout1, b_oe1} == 24'h0, {tag, " R10 ch1 outputs low"}, {8'h0, b_dout1, b_oe1}, 32'h0);
    check({b_dout2, b_oe2} == 24'h0, {tag, " R11 ch2 outputs low"}, {8'h0, b_dout2, b_oe2}, 32'h0);
  endtask

  task automatic access(input bit w, input logic [7:0] ad, input logic [31:0] d,
                        input logic [3:0] bytes, output logic [31:0] got);
    logic [31:0] ea, eb, mk;
    @(negedge clk);
    check(a_ack == 1'b0 && b_ack == 1'b0, "R2 ack low when idle", {30'h0, a_ack, b_ack}, 32'h0);
    ea = w ? 32'h0 : exp_a(ad);
    eb = w ? 32'h0 : exp_b(ad);
    sel = 1'b1; wr = w; addr = ad; wd = d; be = bytes;
    @(negedge clk);
    sel = 1'b0;
    check(a_ack == 1'b1 && b_ack == 1'b1, "R2 ack one cycle after sel", {30'h0, a_ack, b_ack}, 32'h3);
    check(a_rdata == ea, w ? "R2 write rdata zero" : "R1 R5 read dut", a_rdata, ea);
    check(b_rdata == eb, "R10 R11 R12 read dut_b", b_rdata, eb);
    got = a_rdata;
    if (w && ad[7:4] == 0 && ad[1:0] == 0) begin
      mk = lanes(bytes);
      case (ad[3:2])
        2'd0: m_data1 = (m_data1 & ~(mk & ~m_dir1)) | (d & mk & ~m_dir1);
        2'd1: m_dir1  = (m_dir1 & ~mk) | (d & mk);
        2'd2: m_data2 = (m_data2 & ~(mk & ~m_dir2)) | (d & mk & ~m_dir2);
        default: m_dir2 = (m_dir2 & ~mk) | (d & mk);
      endcase
    end
    check_pins(w ? "after write" : "after read");
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    check(a_dout1 == 32'h0 && a_oe1 == 32'h0, "R3 ch1 reset inputs", a_oe1, 32'h0);
    check(a_dout2 == 32'hA5A5_0000, "R3 ch2 data reset", a_dout2, 32'hA5A5_0000);
    check(a_oe2 == 32'hFFFF_0000, "R3 ch2 dir reset", a_oe2, 32'hFFFF_0000);
    check(a_ack == 1'b0, "R3 ack reset", {31'h0, a_ack}, 32'h0);

    // R9: synchronizer latency, old value then new value
    a_pad1 = 32'h1234_5678;
    b_in1  = 12'hABC;
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = 8'h00; be = 4'hF;
    @(negedge clk);
    sel = 1'b0;
    check(a_rdata == 32'h0, "R9 read at edge k+1 still old", a_rdata, 32'h0);
    check(b_rdata == 32'h0, "R9 dut_b read at edge k+1 still old", b_rdata, 32'h0);
    access(1'b0, 8'h00, 32'h0, 4'hF, r);   // R9 new value expected by model

    // R6: upper half output, lower half input
    access(1'b1, 8'h04, 32'h0000_FFFF, 4'hF, r);
    access(1'b1, 8'h00, 32'hDEAD_BEEF, 4'hF, r);
    check(a_dout1 == 32'hDEAD_0000, "R6 input bits not written", a_dout1, 32'hDEAD_0000);
    access(1'b1, 8'h04, 32'h0, 4'hF, r);
    access(1'b0, 8'h00, 32'h0, 4'h0, r);
    check(r == 32'hDEAD_0000, "R6 stored bits kept after turning output", r, 32'hDEAD_0000);
    // R7: single lane write
    access(1'b1, 8'h00, 32'h1122_3344, 4'b0010, r);
    check(a_dout1 == 32'hDEAD_3300, "R7 only lane 1 written", a_dout1, 32'hDEAD_3300);
    // R8: channel 2 ignores pad input, dut_b ignores its pad
    a_pad2 = 32'hFFFF_FFFF; a_in2 = 32'h0000_1234; b_pad1 = 12'hFFF;
    repeat (3) @(negedge clk);
    access(1'b0, 8'h08, 32'h0, 4'h0, r);
    check(r == 32'hA5A5_1234, "R8 dedicated input source", r, 32'hA5A5_1234);
    // R10/R11/R12 writes ignored
    access(1'b1, 8'h0C, 32'h0, 4'hF, r);     // dut drives ch2 all outputs, dut_b ignores
    access(1'b1, 8'h04, 32'h0, 4'hF, r);     // dut_b inputs-only ignores
    access(1'b1, 8'h10, 32'hFFFF_FFFF, 4'hF, r);   // R12 unmapped
    access(1'b1, 8'h01, 32'hFFFF_FFFF, 4'hF, r);   // R12 misaligned
    access(1'b0, 8'h02, 32'h0, 4'hF, r);           // R12 misaligned read

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ad;
      logic [31:0] v;
      if (i % 25 == 0) begin
        a_pad1 = $urandom(); a_in1 = $urandom(); a_pad2 = $urandom(); a_in2 = $urandom();
        b_pad1 = 12'($urandom()); b_in1 = 12'($urandom());
        repeat (3) @(negedge clk);
      end
      v  = $urandom();
      ad = (v[7:4] == 4'hF) ? {v[3:0], 4'h0} : {4'h0, v[9:8], 2'b00};
      access(v[10], ad, $urandom(), 4'($urandom()), r);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule